// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block runs the multiply and divide operations of a 32-bit RISC integer core. It writes their 64-bit results into a pair of dedicated result registers, HI and LO. A command carries a 6-bit function code and two operands. The unit takes a command over a valid/ready handshake and works on it for a fixed number of cycles, using an iterative shift-and-add or shift-and-subtract datapath. When it finishes, it writes both result registers in one clock edge. Signed operations are done on magnitudes, and the sign is corrected on the final cycle.

The core reads the result registers back through a second valid/ready port, using the move-from function codes. Back-pressure works the same way on both ports. While an operation is in flight, `cmd_ready` and `rd_ready` are both low. A command offered in that window is not taken and leaves no trace. A read request is held by the requester until `rd_ready` rises, and the data it then receives is the finished result. No transfer happens in any cycle where valid and ready are not both high.

Top module: `muldiv_hilo`

## Requirements
- R1: A synchronous reset clears HI and LO to zero and leaves the unit idle, with `busy` low and both ready outputs high.
- R2: A command is taken only on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low exactly while `busy` is high. A command offered while busy has no effect on the result or the timing.
- R3: Function code 24 (signed multiply) stores the low word of the 64-bit two's-complement product in LO and the high word in HI.
- R4: Function code 25 (unsigned multiply) stores the low word of the unsigned 64-bit product in LO and the high word in HI.
- R5: Function code 26 (signed divide) stores a quotient truncated toward zero in LO and a remainder carrying the sign of the dividend in HI. The case -2^31 / -1 yields LO = 0x80000000 and HI = 0.
- R6: Function code 27 (unsigned divide) stores the quotient in LO and the remainder in HI.
- R7: Division by zero finishes normally with HI equal to the dividend. For code 27, LO becomes 0xFFFFFFFF. For code 26, LO becomes 0xFFFFFFFF when the dividend is non-negative and 0x00000001 when it is negative.
- R8: After an accepting edge, `busy` stays high for exactly 33 clock cycles. HI and LO change only on the edge at which `busy` falls.
- R9: While `rd_valid` and `rd_ready` are high, `rd_data` shows HI for `rd_func` = 16 and LO for `rd_func` = 18. Any other `rd_func` value gives zero, and `rd_data` is zero whenever `rd_valid` is low.
- R10: `rd_ready` is low while an operation is in flight, so a read request is stalled until the result is written. The value it then returns is the new result.
- R11: A command with a function code outside 24..27 is accepted but does nothing: `busy` stays low and HI and LO keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command (idle) |
| cmd_func | input | 6 | Operation function code |
| cmd_a | input | 32 | First operand (multiplicand or dividend) |
| cmd_b | input | 32 | Second operand (multiplier or divisor) |
| rd_valid | input | 1 | Result-register read requested |
| rd_func | input | 6 | Read function code: 16 selects HI, 18 selects LO |
| rd_ready | output | 1 | Read data is valid this cycle |
| rd_data | output | 32 | Selected result register |
| busy | output | 1 | Operation in flight |

## Verification
On every cycle the assertions check four things. The result registers move only when `busy` falls. Every busy window is exactly 33 cycles long and starts only from an offered command. Reset leaves the registers cleared. A held read returns steady data. The arithmetic itself can only be shown by the bench's scenarios, where a behavioural model is compared with the design on every cycle. The scenarios include sign combinations, the most-negative dividend, division by zero in both forms, commands offered while busy, reads stalled across a whole operation, and unused function codes.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int unsigned FN_W = 6;

  localparam logic [FN_W-1:0] FN_RD_HI  = 6'd16;
  localparam logic [FN_W-1:0] FN_RD_LO  = 6'd18;
  localparam logic [FN_W-1:0] FN_MUL_S  = 6'd24;
  localparam logic [FN_W-1:0] FN_MUL_U  = 6'd25;
  localparam logic [FN_W-1:0] FN_DIV_S  = 6'd26;
  localparam logic [FN_W-1:0] FN_DIV_U  = 6'd27;

  typedef enum logic [1:0] {
    EN_IDLE = 2'd0,
    EN_RUN  = 2'd1,
    EN_FIN  = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic go;
    logic is_div;
    logic is_signed;
  } op_ctl_t;
endpackage

// File: rtl/muldiv_decode.sv
module muldiv_decode
  import muldiv_pkg::*;
(
  input  logic [FN_W-1:0] func,
  output op_ctl_t         ctl
);
  always_comb begin
    ctl = '0;
    unique case (func)
      FN_MUL_S: ctl = '{go: 1'b1, is_div: 1'b0, is_signed: 1'b1};
      FN_MUL_U: ctl = '{go: 1'b1, is_div: 1'b0, is_signed: 1'b0};
      FN_DIV_S: ctl = '{go: 1'b1, is_div: 1'b1, is_signed: 1'b1};
      FN_DIV_U: ctl = '{go: 1'b1, is_div: 1'b1, is_signed: 1'b0};
      default:  ctl = '0;
    endcase
  end
endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_div,
  input  logic         is_signed,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         fin,
  output logic         div_mode,
  output logic         neg_x,
  output logic         neg_a,
  output logic [W-1:0] raw_hi,
  output logic [W-1:0] raw_lo
);
  localparam int unsigned CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  eng_state_e       state_q;
  logic [CNT_W-1:0] step_q;
  logic [W-1:0]     wk_hi_q, wk_lo_q, wk_m_q;
  logic             div_q, negx_q, nega_q;

  // operand magnitudes for the signed forms
  logic         a_neg, b_neg;
  logic [W-1:0] a_mag, b_mag;

  always_comb begin
    a_neg = is_signed & opa[W-1];
    b_neg = is_signed & opb[W-1];
    a_mag = a_neg ? (~opa + 1'b1) : opa;
    b_mag = b_neg ? (~opb + 1'b1) : opb;
  end

  // one iteration of either algorithm
  logic [W:0]   add_sum;
  logic [W:0]   shifted;
  logic [W-1:0] diff;
  logic         fits;
  logic [W-1:0] nx_hi, nx_lo;

  always_comb begin
    add_sum = {1'b0, wk_hi_q} + (wk_lo_q[0] ? {1'b0, wk_m_q} : '0);
    shifted = {wk_hi_q, wk_lo_q[W-1]};
    fits    = (shifted >= {1'b0, wk_m_q});
    diff    = shifted[W-1:0] - wk_m_q;
    if (div_q) begin
      nx_hi = fits ? diff : shifted[W-1:0];
      nx_lo = {wk_lo_q[W-2:0], fits};
    end else begin
      nx_hi = add_sum[W:1];
      nx_lo = {add_sum[0], wk_lo_q[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= EN_IDLE;
      step_q  <= '0;
      wk_hi_q <= '0;
      wk_lo_q <= '0;
      wk_m_q  <= '0;
      div_q   <= 1'b0;
      negx_q  <= 1'b0;
      nega_q  <= 1'b0;
    end else begin
      unique case (state_q)
        EN_IDLE: begin
          if (start) begin
            state_q <= EN_RUN;
            step_q  <= '0;
            wk_hi_q <= '0;
            wk_lo_q <= is_div ? a_mag : b_mag;
            wk_m_q  <= is_div ? b_mag : a_mag;
            div_q   <= is_div;
            negx_q  <= a_neg ^ b_neg;
            nega_q  <= a_neg;
          end
        end
        EN_RUN: begin
          wk_hi_q <= nx_hi;
          wk_lo_q <= nx_lo;
          if (step_q == LAST_STEP) begin
            state_q <= EN_FIN;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        EN_FIN:  state_q <= EN_IDLE;
        default: state_q <= EN_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != EN_IDLE);
  assign fin      = (state_q == EN_FIN);
  assign div_mode = div_q;
  assign neg_x    = negx_q;
  assign neg_a    = nega_q;
  assign raw_hi   = wk_hi_q;
  assign raw_lo   = wk_lo_q;
endmodule

// File: rtl/muldiv_fixup.sv
module muldiv_fixup #(
  parameter int unsigned W = 32
) (
  input  logic         div_mode,
  input  logic         neg_x,
  input  logic         neg_a,
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] prod;
  logic [W-1:0]  quo, rem;

  always_comb begin
    prod = {raw_hi, raw_lo};
    if (neg_x) prod = ~prod + 1'b1;
    quo = neg_x ? (~raw_lo + 1'b1) : raw_lo;
    rem = neg_a ? (~raw_hi + 1'b1) : raw_hi;
    if (div_mode) begin
      res_hi = rem;
      res_lo = quo;
    end else begin
      res_hi = prod[PW-1:W];
      res_lo = prod[W-1:0];
    end
  end
endmodule

// File: rtl/muldiv_hilo_regs.sv
module muldiv_hilo_regs
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_hi,
  input  logic [W-1:0]    wr_lo,
  input  logic            sel_en,
  input  logic [FN_W-1:0] sel_func,
  output logic [W-1:0]    hi_q,
  output logic [W-1:0]    lo_q,
  output logic [W-1:0]    sel_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      hi_q <= wr_hi;
      lo_q <= wr_lo;
    end
  end

  always_comb begin
    sel_data = '0;
    if (sel_en) begin
      if (sel_func == FN_RD_HI)      sel_data = hi_q;
      else if (sel_func == FN_RD_LO) sel_data = lo_q;
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [FN_W-1:0] cmd_func,
  input  logic [W-1:0]    cmd_a,
  input  logic [W-1:0]    cmd_b,
  input  logic            rd_valid,
  input  logic [FN_W-1:0] rd_func,
  output logic            rd_ready,
  output logic [W-1:0]    rd_data,
  output logic            busy
);
  op_ctl_t      ctl;
  logic         start;
  logic         eng_busy, eng_fin, div_mode, neg_x, neg_a;
  logic [W-1:0] raw_hi, raw_lo, res_hi, res_lo;
  logic [W-1:0] hi_q, lo_q;

  muldiv_decode u_decode (
    .func (cmd_func),
    .ctl  (ctl)
  );

  assign start = cmd_valid & cmd_ready & ctl.go;

  muldiv_engine #(.W(W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_div    (ctl.is_div),
    .is_signed (ctl.is_signed),
    .opa       (cmd_a),
    .opb       (cmd_b),
    .busy      (eng_busy),
    .fin       (eng_fin),
    .div_mode  (div_mode),
    .neg_x     (neg_x),
    .neg_a     (neg_a),
    .raw_hi    (raw_hi),
    .raw_lo    (raw_lo)
  );

  muldiv_fixup #(.W(W)) u_fixup (
    .div_mode (div_mode),
    .neg_x    (neg_x),
    .neg_a    (neg_a),
    .raw_hi   (raw_hi),
    .raw_lo   (raw_lo),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
  );

  muldiv_hilo_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (eng_fin),
    .wr_hi    (res_hi),
    .wr_lo    (res_lo),
    .sel_en   (rd_valid),
    .sel_func (rd_func),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .sel_data (rd_data)
  );

  assign busy      = eng_busy;
  assign cmd_ready = ~eng_busy;
  assign rd_ready  = ~eng_busy;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_valid,
  input logic         busy,
  input logic         rd_valid,
  input logic         rd_ready,
  input logic [5:0]   rd_func,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int unsigned CW = $clog2(W + 2) + 1;

  logic          prev_ok;
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) begin
    prev_ok <= ~rst;
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hi_q == '0 && lo_q == '0 && !busy)); // R1

  AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    prev_ok && $rose(busy) |-> $past(cmd_valid)); // R2

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    prev_ok && $fell(busy) |-> bcnt == CW'(W + 1)); // R8

  AST_HILO_AT_END: assert property (@(posedge clk) disable iff (rst)
    prev_ok && !($stable(hi_q) && $stable(lo_q)) |-> $fell(busy)); // R8

  AST_READ_STEADY: assert property (@(posedge clk) disable iff (rst)
    prev_ok && rd_valid && rd_ready && $past(rd_valid && rd_ready) && $stable(rd_func)
      |-> $stable(rd_data)); // R9
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_func   (rd_func),
  .rd_data   (rd_data),
  .hi_q      (hi_q),
  .lo_q      (lo_q)
);

// File: tb/test_muldiv_hilo.sv
`timescale 1ns/1ps
module test_muldiv_hilo;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, cmd_valid, rd_valid;
  logic [5:0]  cmd_func, rd_func;
  logic [31:0] cmd_a, cmd_b;
  logic        cmd_ready, rd_ready, busy;
  logic [31:0] rd_data;

  muldiv_hilo i_muldiv_hilo (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_func(cmd_func), .cmd_a(cmd_a), .cmd_b(cmd_b), .rd_valid(rd_valid),
    .rd_func(rd_func), .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy)
  );

  int    n_chk = 0, n_bad = 0;
  string scen  = "R1";

  logic [31:0] m_hi, m_lo, p_hi, p_lo;
  logic        m_busy;
  int          m_cnt;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // behavioural result of one operation
  task automatic mdl_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] h, output logic [31:0] l);
    longint      sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (f == 6'd24)      p = 64'(sa * sb);
    else if (f == 6'd25) p = {32'b0, a} * {32'b0, b};
    else if (b == 32'd0) p = {a, (f == 6'd27 || !a[31]) ? 32'hFFFF_FFFF : 32'h1};
    else if (f == 6'd26) begin
      q = sa / sb;
      r = sa % sb;
      p = {r[31:0], q[31:0]};
    end else p = {a % b, a / b};
    h = p[63:32];
    l = p[31:0];
  endtask

  // reference model stepped at the edge, compared shortly after it
  always @(posedge clk) begin
    if (rst) begin
      m_hi = '0; m_lo = '0; m_busy = 1'b0; m_cnt = 0;
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 1'b0; m_hi = p_hi; m_lo = p_lo;
      end
    end else if (cmd_valid && cmd_func inside {[6'd24:6'd27]}) begin
      mdl_op(cmd_func, cmd_a, cmd_b, p_hi, p_lo);
      m_busy = 1'b1;
      m_cnt  = 33;
    end
    #2;
    chk("R8", "busy", {31'b0, busy}, {31'b0, m_busy});
    chk("R2", "cmd_ready", {31'b0, cmd_ready}, {31'b0, !m_busy});
    chk("R10", "rd_ready", {31'b0, rd_ready}, {31'b0, !m_busy});
    if (rd_valid && !m_busy) begin
      if (rd_func == 6'd16)      chk(scen, "HI", rd_data, m_hi);
      else if (rd_func == 6'd18) chk(scen, "LO", rd_data, m_lo);
      else                       chk("R9", "other code", rd_data, 32'd0);
    end else if (!rd_valid) begin
      chk("R9", "idle data", rd_data, 32'd0);
    end
  end

  task automatic read_both();
    @(negedge clk); rd_valid = 1'b1; rd_func = 6'd16;
    @(negedge clk); rd_func = 6'd18;
    @(negedge clk); rd_func = 6'd5;
    @(negedge clk); rd_valid = 1'b0;
  endtask

  task automatic op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_func = f; cmd_a = a; cmd_b = b;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (34) @(negedge clk);
    read_both();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; rd_valid = 1'b0;
    cmd_func = '0; rd_func = '0; cmd_a = '0; cmd_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    scen = "R1"; read_both();

    scen = "R3";
    op(6'd24, 32'hFFFF_FFFD, 32'd7);
    op(6'd24, 32'h8000_0000, 32'h8000_0000);
    op(6'd24, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    scen = "R4";
    op(6'd25, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    op(6'd25, 32'h1234_5678, 32'h9ABC_DEF0);
    scen = "R5";
    op(6'd26, 32'hFFFF_FFF9, 32'd2);
    op(6'd26, 32'd7, 32'hFFFF_FFFE);
    op(6'd26, 32'h8000_0000, 32'hFFFF_FFFF);
    scen = "R6";
    op(6'd27, 32'hFFFF_FFFF, 32'd10);
    op(6'd27, 32'd5, 32'd9);
    scen = "R7";
    op(6'd27, 32'd1234, 32'd0);
    op(6'd26, 32'hFFFF_FFFB, 32'd0);
    op(6'd26, 32'd5, 32'd0);

    // R2: command offered while busy must be ignored
    scen = "R2";
    @(negedge clk); cmd_valid = 1'b1; cmd_func = 6'd25; cmd_a = 32'd1000; cmd_b = 32'd3000;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_func = 6'd24; cmd_a = 32'hDEAD_BEEF; cmd_b = 32'h55;
    repeat (2) @(negedge clk); cmd_valid = 1'b0;
    repeat (32) @(negedge clk);
    read_both();

    // R10: read held across a whole operation
    scen = "R10";
    @(negedge clk); cmd_valid = 1'b1; cmd_func = 6'd27; cmd_a = 32'd100; cmd_b = 32'd7;
    rd_valid = 1'b1; rd_func = 6'd18;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (36) @(negedge clk);
    rd_func = 6'd16;
    @(negedge clk); rd_valid = 1'b0;

    // R11: unused function codes
    scen = "R11";
    op(6'd3, 32'd77, 32'd88);
    op(6'd28, 32'd1, 32'd1);

    for (int i = 0; i < 48; i++) begin
      logic [5:0]  f;
      logic [31:0] a, b;
      f = 6'd24 + 6'($urandom % 4);
      a = $urandom;
      b = (i % 3 == 0) ? ($urandom % 16) : $urandom;
      case (f)
        6'd24:   scen = "R3";
        6'd25:   scen = "R4";
        6'd26:   scen = "R5";
        default: scen = "R6";
      endcase
      op(f, a, b);
    end
    summary();
  end
endmodule